// File: doc/BRIEF.md
# Three-Counter Performance Monitor

This block counts clock cycles and selected core events so that software can measure how a piece of code behaves. It holds one free-running cycle counter and two event counters, all 32 bits wide. Each event counter watches one line of an event input vector. The line is chosen by an 8-bit code in the control word. When a counter wraps past its all-ones value it raises a sticky flag. Any flag whose interrupt enable is set drives a level interrupt.

Software reaches the unit through a minimal register port. Each cycle there is one write strobe and a 2-bit word address; read data is returned combinationally for the addressed word. Address 0 is the packed control/status word. Address 1 is the cycle counter, address 2 is event counter 0 and address 3 is event counter 1. The control word also carries the counting enable, the one-shot counter clears, a divide-by-64 mode for the cycle counter, and the interrupt enables. The overflow flags sit in the same word and are cleared by writing ones to them. The two event codes are there as well.

Top module: `perf_mon`

## Requirements
- R1: After reset, all counters read 0, irq is low, and the control word reads 0x0FFFF000: both event codes are 0xFF and every other field is 0.
- R2: Control bit 0 gates all counting. While it is 0 no counter moves. While it is 1 and bit 3 is 0, the cycle counter adds one on every clock.
- R3: With bits 0 and 3 both set, the cycle counter adds one once every 64 clocks. Writing the control word with bit 2 set restarts that 64-clock interval.
- R4: Event counter 0 takes its code from control bits 19:12 and event counter 1 from bits 27:20. In a counting clock, a counter adds one when the input line numbered by its code is high.
- R5: A counter whose code is 0xFF, or any other code at or above the number of event lines, never adds, whatever the event inputs do.
- R6: Writing control bit 1 as 1 zeroes both event counters. Writing control bit 2 as 1 zeroes the cycle counter. Both bits always read back as 0.
- R7: A counter that adds one while holding 0xFFFFFFFF becomes 0 and sets its overflow flag. The flags are bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R8: A control write with a 1 in a flag position clears that flag, and a 0 leaves it alone. An overflow in the same clock as its clear leaves the flag set.
- R9: An overflow of one counter never changes the flags of the other counters.
- R10: irq is high exactly when some flag is set together with its enable. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R11: Control bits 7, 11 and 31:28 read as 0 whatever was written to them.
- R12: A direct write to a counter takes the written value even in a clock where the counter would have added or wrapped, and then no flag is set.
- R13: Read data always shows the current value of the addressed word. Under mixed random traffic every word matches a model built from R1 to R12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe for the addressed word |
| busAddr | input | 2 | Word address: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the addressed word (combinational) |
| eventIn | input | 16 | One pulse line per event code 0 to 15 |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives a flag clear in the very clock a counter wraps. A design that let the clear win would lose an overflow and silently drop an interrupt. It also loads a counter holding all ones in a clock where it would otherwise add. A design that let the increment win would show a spurious flag or the wrong value. The divided mode is checked on both sides of the 64th clock and after a restart halfway through, which exposes off-by-one prescalers and a prescaler that ignores the restart. Out-of-range codes are checked with every event line high, so a counter that indexed past the vector would count.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

  localparam int SEL_W     = 8;
  localparam int NUM_CNT   = 3;
  localparam int NUM_EVCNT = 2;
  localparam int IDX_EV0   = 0;
  localparam int IDX_EV1   = 1;
  localparam int IDX_CYC   = 2;

  // control word bit positions (software decodes these)
  localparam int BIT_EN     = 0;
  localparam int BIT_EVCLR  = 1;
  localparam int BIT_CYCCLR = 2;
  localparam int BIT_DIV    = 3;
  localparam int IE_LSB     = 4;
  localparam int PAD_LO     = 7;
  localparam int FLAG_LSB   = 8;
  localparam int PAD_MID    = 11;
  localparam int SEL_LSB    = 12;
  localparam int PAD_TOP    = SEL_LSB + NUM_EVCNT * SEL_W;

  localparam logic [SEL_W-1:0] SEL_NONE = 8'hFF;

  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_CYC = 2'd1;
  localparam logic [1:0] ADDR_EV0 = 2'd2;
  localparam logic [1:0] ADDR_EV1 = 2'd3;

  typedef struct packed {
    logic                             countEn;
    logic                             divMode;
    logic                             evClr;
    logic                             cycClr;
    logic [NUM_CNT-1:0]               cntWr;
    logic [NUM_EVCNT-1:0][SEL_W-1:0]  evSel;
  } pmStrobe_t;

  function automatic logic [1:0] cntAddr(input int idx);
    case (idx)
      IDX_EV0: return ADDR_EV0;
      IDX_EV1: return ADDR_EV1;
      default: return ADDR_CYC;
    endcase
  endfunction

endpackage

// File: rtl/perf_mon_counter.sv
module perf_mon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] cntQ,
  output logic         wrapPulse
);

  // a load or clear in the same clock suppresses the wrap
  assign wrapPulse = step && !load && !clear && (cntQ == {W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cntQ <= '0;
    else if (load)  cntQ <= loadVal;
    else if (clear) cntQ <= '0;
    else if (step)  cntQ <= cntQ + 1'b1;
  end

endmodule

// File: rtl/perf_mon_dp.sv
module perf_mon_dp
  import perf_mon_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 16,
  parameter int DIV_LOG = 6
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  pmStrobe_t                       strb,
  input  logic [DATA_W-1:0]               wrData,
  input  logic [NUM_EVT-1:0]              eventIn,
  output logic [NUM_CNT-1:0][DATA_W-1:0]  cntVal,
  output logic [NUM_CNT-1:0]              ovfPulse
);

  localparam int EVT_IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [DIV_LOG-1:0]  preQ;
  logic                cycTick;
  logic [NUM_CNT-1:0]  stepVec;
  logic [NUM_CNT-1:0]  clrVec;

  // prescaler for the divided cycle mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             preQ <= '0;
    else if (strb.cycClr)                  preQ <= '0;
    else if (strb.countEn && strb.divMode) preQ <= preQ + 1'b1;
  end

  assign cycTick = strb.countEn && (!strb.divMode || (preQ == {DIV_LOG{1'b1}}));

  assign stepVec[IDX_CYC] = cycTick;
  assign clrVec[IDX_CYC]  = strb.cycClr;

  for (genvar k = 0; k < NUM_EVCNT; k++) begin : g_evsel
    logic selValid;
    assign selValid = (strb.evSel[k] != SEL_NONE) && (int'(strb.evSel[k]) < NUM_EVT);
    assign stepVec[k] = strb.countEn && selValid && eventIn[strb.evSel[k][EVT_IDX_W-1:0]];
    assign clrVec[k]  = strb.evClr;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    perf_mon_counter #(.W(DATA_W)) u_cnt (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strb.cntWr[i]),
      .loadVal  (wrData),
      .clear    (clrVec[i]),
      .step     (stepVec[i]),
      .cntQ     (cntVal[i]),
      .wrapPulse(ovfPulse[i])
    );
  end

endmodule

// File: rtl/perf_mon_ctrl.sv
module perf_mon_ctrl
  import perf_mon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [1:0]         busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic [NUM_CNT-1:0] ovfPulse,
  output pmStrobe_t          strb,
  output logic [DATA_W-1:0]  ctlWord,
  output logic [NUM_CNT-1:0] flagQ,
  output logic [NUM_CNT-1:0] ieQ,
  output logic               countEn,
  output logic               irq
);

  logic                            enQ;
  logic                            divQ;
  logic [NUM_EVCNT-1:0][SEL_W-1:0] selQ;
  logic                            ctlWr;
  logic [NUM_CNT-1:0]              flagClr;
  logic                            unusedWrBits;

  assign ctlWr        = busWrEn && (busAddr == ADDR_CTL);
  assign flagClr      = ctlWr ? busWrData[FLAG_LSB +: NUM_CNT] : '0;
  assign unusedWrBits = ^{busWrData[DATA_W-1:PAD_TOP], busWrData[PAD_MID], busWrData[PAD_LO]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      divQ  <= 1'b0;
      ieQ   <= '0;
      flagQ <= '0;
      selQ  <= {NUM_EVCNT{SEL_NONE}};
    end else begin
      // a fresh wrap beats a clear in the same clock
      flagQ <= (flagQ & ~flagClr) | ovfPulse;
      if (ctlWr) begin
        enQ  <= busWrData[BIT_EN];
        divQ <= busWrData[BIT_DIV];
        ieQ  <= busWrData[IE_LSB +: NUM_CNT];
        for (int k = 0; k < NUM_EVCNT; k++)
          selQ[k] <= busWrData[SEL_LSB + k*SEL_W +: SEL_W];
      end
    end
  end

  always_comb begin
    strb.countEn = enQ;
    strb.divMode = divQ;
    strb.evClr   = ctlWr && busWrData[BIT_EVCLR];
    strb.cycClr  = ctlWr && busWrData[BIT_CYCCLR];
    strb.evSel   = selQ;
    for (int i = 0; i < NUM_CNT; i++)
      strb.cntWr[i] = busWrEn && (busAddr == cntAddr(i));
  end

  always_comb begin
    ctlWord                        = '0;
    ctlWord[BIT_EN]                = enQ;
    ctlWord[BIT_DIV]               = divQ;
    ctlWord[IE_LSB +: NUM_CNT]     = ieQ;
    ctlWord[FLAG_LSB +: NUM_CNT]   = flagQ;
    for (int k = 0; k < NUM_EVCNT; k++)
      ctlWord[SEL_LSB + k*SEL_W +: SEL_W] = selQ[k];
  end

  assign countEn = enQ;
  assign irq     = |(flagQ & ieQ);

endmodule

// File: rtl/perf_mon.sv
module perf_mon
  import perf_mon_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 16,
  parameter int DIV_LOG = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [1:0]         busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_EVT-1:0] eventIn,
  output logic               irq
);

  pmStrobe_t                      strb;
  logic [DATA_W-1:0]              ctlWord;
  logic [NUM_CNT-1:0]             flagQ;
  logic [NUM_CNT-1:0]             ieQ;
  logic                           countEn;
  logic [NUM_CNT-1:0]             ovfPulse;
  logic [NUM_CNT-1:0][DATA_W-1:0] cntVal;

  perf_mon_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .ovfPulse (ovfPulse),
    .strb     (strb),
    .ctlWord  (ctlWord),
    .flagQ    (flagQ),
    .ieQ      (ieQ),
    .countEn  (countEn),
    .irq      (irq)
  );

  perf_mon_dp #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT), .DIV_LOG(DIV_LOG)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (busWrData),
    .eventIn (eventIn),
    .cntVal  (cntVal),
    .ovfPulse(ovfPulse)
  );

  always_comb begin
    case (busAddr)
      ADDR_CTL: busRdData = ctlWord;
      ADDR_CYC: busRdData = cntVal[IDX_CYC];
      ADDR_EV0: busRdData = cntVal[IDX_EV0];
      default:  busRdData = cntVal[IDX_EV1];
    endcase
  end

endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk #(
  parameter int DATA_W = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   busWrEn,
  input logic [1:0]             busAddr,
  input logic [DATA_W-1:0]      busWrData,
  input logic [DATA_W-1:0]      busRdData,
  input logic                   irq,
  input logic [2:0]             flagQ,
  input logic [2:0]             ieQ,
  input logic [2:0][DATA_W-1:0] cntVal,
  input logic                   countEn
);

  // R2: nothing moves while counting is off and the bus is quiet
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !busWrEn) |=> $stable(cntVal));

  // R7: a cycle-counter wrap without bus traffic leaves its flag set
  a_r7_cyc_wrap_flag: assert property (@(posedge clk) disable iff (!rstN)
    ((cntVal[2] == {DATA_W{1'b1}}) && !busWrEn) ##1 (cntVal[2] == '0) |-> flagQ[2]);

  // R8: a flag only drops through a write-one-to-clear
  for (genvar i = 0; i < 3; i++) begin : g_flag
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[i] && !(busWrEn && busAddr == 2'd0 && busWrData[8+i])) |=> flagQ[i]);
  end

  // R10: no interrupt without a flag, none when all enables are off
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flagQ != 3'b000));
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (ieQ == 3'b000) |-> !irq);

  // R11 and R6: padding and one-shot clear bits read as zero
  a_r11_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0) |-> (busRdData[31:28] == 4'h0 && !busRdData[11] &&
                           !busRdData[7] && busRdData[2:1] == 2'b00));

  // R12: a direct load lands exactly
  a_r12_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd1) |=> (cntVal[2] == $past(busWrData)));

endmodule

bind perf_mon perf_mon_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .irq      (irq),
  .flagQ    (flagQ),
  .ieQ      (ieQ),
  .cntVal   (cntVal),
  .countEn  (countEn)
);

// File: tb/perf_mon_bench.sv
`timescale 1ns/1ps
module perf_mon_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWrData = 32'd0;
  logic [31:0] busRdData;
  logic [15:0] eventIn = 16'd0;
  logic        irq;

  int checkCnt = 0;
  int failCnt  = 0;

  // reference state
  logic        mEn, mDiv;
  logic [2:0]  mIe, mFlag;
  logic [7:0]  mSel [2];
  logic [31:0] mCnt [3];
  logic [5:0]  mPre;

  always #2.5 clk = ~clk;

  perf_mon u_perf_mon (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .eventIn(eventIn), .irq(irq)
  );

  task automatic modelReset();
    mEn = 0; mDiv = 0; mIe = 0; mFlag = 0; mPre = 0;
    mSel[0] = 8'hFF; mSel[1] = 8'hFF;
    for (int j = 0; j < 3; j++) mCnt[j] = 0;
  endtask

  task automatic modelStep(input bit wr, input logic [1:0] a, input logic [31:0] d,
                           input logic [15:0] ev);
    logic [2:0] inc;
    logic [2:0] ovf;
    logic [2:0] clrMask;
    bit ctlW;
    ctlW = wr && (a == 2'd0);
    inc[2] = mEn && (!mDiv || mPre == 6'd63);
    for (int k = 0; k < 2; k++)
      inc[k] = mEn && mSel[k] != 8'hFF && mSel[k] < 8'd16 && ev[mSel[k][3:0]];
    ovf = 0;
    for (int j = 0; j < 3; j++) begin
      logic [1:0] ja;
      bit clr;
      ja  = (j == 2) ? 2'd1 : 2'(j + 2);
      clr = ctlW && ((j == 2) ? d[2] : d[1]);
      if (wr && a == ja) mCnt[j] = d;
      else if (clr) mCnt[j] = 0;
      else if (inc[j]) begin
        ovf[j] = (mCnt[j] == 32'hFFFFFFFF);
        mCnt[j] = mCnt[j] + 1;
      end
    end
    if (ctlW && d[2]) mPre = 0;
    else if (mEn && mDiv) mPre = mPre + 1;
    clrMask = ctlW ? d[10:8] : 3'b000;
    mFlag = (mFlag & ~clrMask) | ovf;
    if (ctlW) begin
      mEn = d[0]; mDiv = d[3]; mIe = d[6:4];
      mSel[0] = d[19:12]; mSel[1] = d[27:20];
    end
  endtask

  function automatic logic [31:0] expWord(input logic [1:0] a);
    case (a)
      2'd0: return {4'h0, mSel[1], mSel[0], 1'b0, mFlag, 1'b0, mIe, mDiv, 2'b00, mEn};
      2'd1: return mCnt[2];
      2'd2: return mCnt[0];
      default: return mCnt[1];
    endcase
  endfunction

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // called just after a falling edge
  task automatic checkAll(input string req);
    checkVal(req, "irq", {31'd0, irq}, {31'd0, |(mFlag & mIe)});
    for (int a = 0; a < 4; a++) begin
      busAddr = 2'(a);
      #0.1;
      checkVal(req, $sformatf("word%0d", a), busRdData, expWord(2'(a)));
    end
  endtask

  task automatic step(input bit wr, input logic [1:0] a, input logic [31:0] d,
                      input logic [15:0] ev);
    busWrEn = wr; busAddr = a; busWrData = d; eventIn = ev;
    @(posedge clk);
    modelStep(wr, a, d, ev);
    @(negedge clk);
    busWrEn = 1'b0; eventIn = 16'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0, 16'd0);
  endtask

  task automatic ctl(input logic [31:0] d);
    step(1'b1, 2'd0, d, 16'd0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
  endtask

  initial begin
    #900000;
    checkCnt++; failCnt++;
    $display("FAIL R13 watchdog: actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    idle(5);
    checkAll("R2");
    ctl(32'h0FFFF001);
    idle(10);
    checkAll("R2");

    ctl(32'hFFFFFFFF);
    checkAll("R11");

    // divided mode around the 64th clock, then a restart midway
    ctl(32'h0FFFF00D);
    idle(62); checkAll("R3");
    idle(1);  checkAll("R3");
    idle(1);  checkAll("R3");
    idle(64); checkAll("R3");
    idle(30);
    ctl(32'h0FFFF00D);
    idle(40); checkAll("R3");
    idle(23); checkAll("R3");

    // event selection: counter 0 on line 3, counter 1 on line 10
    ctl(32'h00A03001);
    step(1'b0, 2'd0, 0, 16'h0008);
    step(1'b0, 2'd0, 0, 16'h0400);
    step(1'b0, 2'd0, 0, 16'h0408);
    checkAll("R4");
    step(1'b0, 2'd0, 0, 16'hFFFF);
    step(1'b0, 2'd0, 0, 16'hFBF7);
    checkAll("R4");

    // unused code and out-of-range code
    ctl(32'h014FF001);
    for (int i = 0; i < 5; i++) step(1'b0, 2'd0, 0, 16'hFFFF);
    checkAll("R5");

    // one-shot clears
    ctl(32'h014FF003);
    checkAll("R6");
    idle(3);
    ctl(32'h014FF005);
    checkAll("R6");

    // wrap of the cycle counter, interrupt on cycle flag
    ctl(32'h0FF00041);
    step(1'b1, 2'd1, 32'hFFFFFFFD, 0);
    idle(2); checkAll("R7");
    idle(1); checkAll("R7");
    checkAll("R10");
    step(1'b1, 2'd2, 32'hFFFFFFFF, 0);
    step(1'b0, 2'd0, 0, 16'h0001);
    checkAll("R9");
    ctl(32'h0FF00021);
    checkAll("R10");

    // write-one-to-clear, write-zero, clear racing a wrap
    ctl(32'h0FF00421);
    checkAll("R8");
    ctl(32'h0FF00021);
    checkAll("R8");
    step(1'b1, 2'd1, 32'hFFFFFFFE, 0);
    step(1'b0, 2'd0, 0, 0);
    ctl(32'h0FF00421);
    checkAll("R8");

    // direct load beats increment and wrap
    ctl(32'h0FF00761);
    step(1'b1, 2'd1, 32'hFFFFFFFF, 0);
    step(1'b1, 2'd1, 32'h12345678, 0);
    checkAll("R12");
    step(1'b1, 2'd2, 32'hFFFFFFFF, 0);
    step(1'b1, 2'd2, 32'h00000042, 16'h0001);
    checkAll("R12");

    // mixed random traffic
    for (int it = 0; it < 3000; it++) begin
      bit wr;
      logic [1:0] a;
      logic [31:0] d;
      wr = ($urandom % 6) == 0;
      a  = 2'($urandom % 4);
      d  = $urandom;
      if (a == 2'd0) begin
        d[19:12] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 20);
        d[27:20] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 20);
        d[0]     = ($urandom % 5) != 0;
      end else if ($urandom % 3 == 0) begin
        d = 32'hFFFFFFF8 + 32'($urandom % 8);
      end
      step(wr, a, d, 16'($urandom));
      if (it % 4 == 3) checkAll("R13");
    end

    summary();
    $finish;
  end

endmodule